// File: doc/BRIEF.md
# Card UART Parity Error Counter with Retry Tracking

This block watches parity on the character stream of a smart-card UART and raises a sticky error flag once a programmable number of bad events has built up. In receive mode it checks each incoming character and counts those with a parity error. In transmit mode it counts how many times the card has rejected the same outgoing character with a NAK. Either count can trip the flag when it equals a 3-bit limit.

The protocol select changes how the block behaves. Under the character protocol (T=0) a bad received character is kept out of the receive FIFO, because the card will send it again, and both counters are active. Under the block protocol (T=1) every received character goes to the FIFO, errors and all, and no counting takes place. The surrounding UART supplies one strobe at the receive decision point (10.5 ETU) and one at the transmit decision point (11.5 ETU). It also supplies a NAK detect pulse and a pulse each time a new character is loaded for transmit.

Top module: `card_parity_guard`

## Requirements
- R1: While in reset and right after it, `err_flag_o` and `fifo_we_o` are 0.
- R2: Parity is even. A received character is good when data bits plus parity bit hold an even number of ones, and bad otherwise.
- R3: In receive mode with protocol T=0 (`proto_t1_i`=0), a good character gives a one-cycle `fifo_we_o` pulse, with `fifo_data_o` equal to the data, in the cycle after `rx_done_i`. A bad character gives no write.
- R4: With `proto_t1_i`=1, every received character is written whatever its parity, and parity errors and NAKs never set the flag.
- R5: In receive mode with T=0, the flag sets in the cycle after the `rx_done_i` strobe whose bad character brings the total bad-character count to `limit_i`, and not earlier. Good characters between bad ones do not reset the count. The count saturates at its maximum.
- R6: In transmit mode with T=0, a NAK seen during a character is counted at that character's `tx_end_i` strobe. The flag sets in the cycle after the strobe at which the NAK count for the same character equals `limit_i`.
- R7: The NAK count returns to 0 when a character ends without a NAK, and when `tx_load_i` pulses.
- R8: `limit_i`=0 never sets the flag.
- R9: Once set, the flag stays set until `flag_clr_i` pulses. The pulse clears the flag and the receive error count in the next cycle.
- R10: `rx_done_i` has no effect in transmit mode (no write, no count), and `tx_end_i` and `tx_nak_i` have no effect in receive mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| proto_t1_i | input | 1 | 0 = protocol T=0, 1 = protocol T=1 |
| limit_i | input | 3 | Error threshold; 0 disables the flag |
| tx_mode_i | input | 1 | 1 = transmit mode, 0 = receive mode |
| rx_done_i | input | 1 | Receive decision strobe (10.5 ETU) |
| rx_data_i | input | 8 | Received data bits |
| rx_par_i | input | 1 | Received parity bit |
| tx_load_i | input | 1 | New transmit character loaded |
| tx_nak_i | input | 1 | Card NAK detected for the current character |
| tx_end_i | input | 1 | Transmit decision strobe (11.5 ETU) |
| flag_clr_i | input | 1 | Clear the flag and the receive error count |
| err_flag_o | output | 1 | Sticky parity error flag |
| fifo_we_o | output | 1 | Receive FIFO write enable |
| fifo_data_o | output | 8 | Receive FIFO write data |

## Verification
Received characters are driven with both even and odd ones counts across data and parity, so the good/bad decision and the FIFO suppression are checked separately from the counting. Bad characters are mixed with good ones to show that the receive count is cumulative, not consecutive, and the same mix is repeated under T=1 to show pass-through with no flag. Transmit sequences of repeated NAKs are set against sequences broken by a clean send or a load, which separates per-character retry counting from plain accumulation. Limit zero, the clear pulse and strobes arriving in the wrong mode complete the set.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
  localparam int unsigned CHAR_W = 8;
  localparam int unsigned THR_W  = 3;
endpackage

// File: rtl/cpg_parity_chk.sv
module cpg_parity_chk #(
  parameter int unsigned DATA_W = cpg_pkg::CHAR_W
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic              par_i,
  output logic              bad_o
);
  // even parity: odd total ones means error
  assign bad_o = ^{data_i, par_i};
endmodule

// File: rtl/cpg_err_cnt.sv
module cpg_err_cnt #(
  parameter int unsigned CNT_W = cpg_pkg::THR_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] next_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, base;

  always_comb begin
    base   = clr_i ? '0 : cnt_q;
    next_o = base;
    if (inc_i && base != CNT_MAX) next_o = base + CNT_W'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= next_o;
  end

  assert_cnt_sat_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX);
endmodule

// File: rtl/card_parity_guard.sv
module card_parity_guard #(
  parameter int unsigned DATA_W = cpg_pkg::CHAR_W,
  parameter int unsigned THR_W  = cpg_pkg::THR_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              proto_t1_i,
  input  logic [THR_W-1:0]  limit_i,
  input  logic              tx_mode_i,
  input  logic              rx_done_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_par_i,
  input  logic              tx_load_i,
  input  logic              tx_nak_i,
  input  logic              tx_end_i,
  input  logic              flag_clr_i,
  output logic              err_flag_o,
  output logic              fifo_we_o,
  output logic [DATA_W-1:0] fifo_data_o
);
  logic rx_bad, rx_ev, tx_ev, t0_mode;
  logic rx_inc, tx_inc, tx_clr, nak_now, nak_seen_q;
  logic rx_hit, tx_hit, limit_on;
  logic [THR_W-1:0] rx_next, tx_next;

  assign t0_mode  = ~proto_t1_i;
  assign rx_ev    = rx_done_i & ~tx_mode_i;
  assign tx_ev    = tx_end_i & tx_mode_i;
  assign limit_on = (limit_i != '0);

  cpg_parity_chk #(.DATA_W(DATA_W)) u_par (
    .data_i (rx_data_i),
    .par_i  (rx_par_i),
    .bad_o  (rx_bad)
  );

  // receive side: cumulative bad-character count
  assign rx_inc = rx_ev & t0_mode & rx_bad;

  cpg_err_cnt #(.CNT_W(THR_W)) u_rx_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (flag_clr_i),
    .inc_i  (rx_inc),
    .next_o (rx_next)
  );

  // transmit side: NAK retries of the current character
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 nak_seen_q <= 1'b0;
    else if (tx_ev || tx_load_i) nak_seen_q <= 1'b0;
    else if (tx_nak_i && tx_mode_i) nak_seen_q <= 1'b1;
  end

  assign nak_now = nak_seen_q | (tx_nak_i & tx_mode_i);
  assign tx_inc  = tx_ev & t0_mode & nak_now;
  assign tx_clr  = tx_load_i | (tx_ev & ~nak_now) | proto_t1_i;

  cpg_err_cnt #(.CNT_W(THR_W)) u_tx_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (tx_clr),
    .inc_i  (tx_inc),
    .next_o (tx_next)
  );

  assign rx_hit = rx_inc && limit_on && (rx_next == limit_i);
  assign tx_hit = tx_inc && limit_on && (tx_next == limit_i);

  // set wins over clear so a coincident event is not lost
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               err_flag_o <= 1'b0;
    else if (rx_hit || tx_hit) err_flag_o <= 1'b1;
    else if (flag_clr_i)       err_flag_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fifo_we_o   <= 1'b0;
      fifo_data_o <= '0;
    end else begin
      fifo_we_o <= rx_ev & (proto_t1_i | ~rx_bad);
      if (rx_ev) fifo_data_o <= rx_data_i;
    end
  end

  assert_we_after_rx_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_we_o |-> $past(rx_done_i && !tx_mode_i));

  assert_bad_blocked_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_done_i && !tx_mode_i && !proto_t1_i && (^{rx_data_i, rx_par_i})) |=> !fifo_we_o);

  assert_t1_no_flag_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> !$past(proto_t1_i));

  assert_flag_on_strobe_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> $past(rx_done_i || tx_end_i));

  assert_zero_limit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_flag_o) |-> $past(limit_i) != '0);

  assert_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_clr_i && !rx_done_i && !tx_end_i) |=> !err_flag_o);

  assert_sticky_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_flag_o && !flag_clr_i) |=> err_flag_o);
endmodule

// File: tb/card_parity_guard_tb.sv
module card_parity_guard_tb;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       proto_t1_i = 1'b0;
  logic [2:0] limit_i = 3'd0;
  logic       tx_mode_i = 1'b0;
  logic       rx_done_i = 1'b0;
  logic [7:0] rx_data_i = 8'h00;
  logic       rx_par_i = 1'b0;
  logic       tx_load_i = 1'b0;
  logic       tx_nak_i = 1'b0;
  logic       tx_end_i = 1'b0;
  logic       flag_clr_i = 1'b0;
  logic       err_flag_o, fifo_we_o;
  logic [7:0] fifo_data_o;

  int checks = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  card_parity_guard u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .proto_t1_i(proto_t1_i), .limit_i(limit_i),
    .tx_mode_i(tx_mode_i), .rx_done_i(rx_done_i), .rx_data_i(rx_data_i),
    .rx_par_i(rx_par_i), .tx_load_i(tx_load_i), .tx_nak_i(tx_nak_i),
    .tx_end_i(tx_end_i), .flag_clr_i(flag_clr_i), .err_flag_o(err_flag_o),
    .fifo_we_o(fifo_we_o), .fifo_data_o(fifo_data_o)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // all drives start and end on a falling edge
  task automatic rx_char(input logic [7:0] d, input logic p);
    rx_data_i = d; rx_par_i = p; rx_done_i = 1'b1;
    @(negedge clk);
    rx_done_i = 1'b0;
  endtask

  task automatic tx_char(input logic nak);
    if (nak) begin
      tx_nak_i = 1'b1; @(negedge clk); tx_nak_i = 1'b0;
    end
    tx_end_i = 1'b1; @(negedge clk); tx_end_i = 1'b0;
  endtask

  task automatic do_clear();
    flag_clr_i = 1'b1; @(negedge clk); flag_clr_i = 1'b0;
  endtask

  task automatic do_load();
    tx_load_i = 1'b1; @(negedge clk); tx_load_i = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 flag in reset", err_flag_o, 0);
    chk("R1 we in reset", fifo_we_o, 0);
    rst_ni = 1'b1;
    @(negedge clk);
    chk("R1 flag after reset", err_flag_o, 0);
    chk("R1 we after reset", fifo_we_o, 0);
  endtask

  task automatic t_rx_store();
    proto_t1_i = 1'b0; tx_mode_i = 1'b0; limit_i = 3'd7; do_clear();
    rx_char(8'h03, 1'b0);
    chk("R2 R3 good even write", fifo_we_o, 1);
    chk("R3 data", fifo_data_o, 8'h03);
    @(negedge clk);
    chk("R3 one-cycle write", fifo_we_o, 0);
    rx_char(8'h01, 1'b1);
    chk("R2 good with parity 1", fifo_we_o, 1);
    rx_char(8'h01, 1'b0);
    chk("R2 R3 bad not written", fifo_we_o, 0);
    rx_char(8'hFF, 1'b1);
    chk("R2 R3 bad 9 ones not written", fifo_we_o, 0);
  endtask

  task automatic t_rx_limit();
    proto_t1_i = 1'b0; tx_mode_i = 1'b0; limit_i = 3'd3; do_clear();
    rx_char(8'h07, 1'b0);
    chk("R5 one bad no flag", err_flag_o, 0);
    rx_char(8'h00, 1'b0);
    rx_char(8'h10, 1'b0);
    chk("R5 two bad no flag", err_flag_o, 0);
    rx_char(8'h80, 1'b0);
    chk("R5 third bad sets flag", err_flag_o, 1);
    rx_char(8'h00, 1'b0);
    chk("R9 flag sticky", err_flag_o, 1);
    do_clear();
    chk("R9 clear drops flag", err_flag_o, 0);
    rx_char(8'h01, 1'b0);
    rx_char(8'h01, 1'b0);
    chk("R9 count reset by clear", err_flag_o, 0);
    rx_char(8'h01, 1'b0);
    chk("R9 flag after fresh count", err_flag_o, 1);
    limit_i = 3'd7; do_clear();
    for (int i = 0; i < 9; i++) rx_char(8'h01, 1'b0);
    chk("R5 flag at limit 7 with saturation", err_flag_o, 1);
  endtask

  task automatic t_t1();
    proto_t1_i = 1'b1; tx_mode_i = 1'b0; limit_i = 3'd1; do_clear();
    rx_char(8'h01, 1'b0);
    chk("R4 bad written under T1", fifo_we_o, 1);
    chk("R4 data under T1", fifo_data_o, 8'h01);
    for (int i = 0; i < 4; i++) rx_char(8'h02, 1'b0);
    chk("R4 no flag under T1 rx", err_flag_o, 0);
    tx_mode_i = 1'b1; do_load();
    tx_char(1'b1); tx_char(1'b1);
    chk("R4 no flag under T1 tx", err_flag_o, 0);
    proto_t1_i = 1'b0; tx_mode_i = 1'b0; limit_i = 3'd2;
    rx_char(8'h04, 1'b0);
    chk("R4 no count kept from T1", err_flag_o, 0);
  endtask

  task automatic t_tx_retry();
    proto_t1_i = 1'b0; tx_mode_i = 1'b1; limit_i = 3'd2; do_clear(); do_load();
    tx_char(1'b1);
    chk("R6 one NAK no flag", err_flag_o, 0);
    tx_char(1'b1);
    chk("R6 second NAK sets flag", err_flag_o, 1);
    do_clear(); do_load();
    tx_char(1'b1); tx_char(1'b0); tx_char(1'b1);
    chk("R7 clean send resets", err_flag_o, 0);
    do_load();
    tx_char(1'b1); do_load(); tx_char(1'b1);
    chk("R7 load resets", err_flag_o, 0);
    tx_char(1'b1);
    chk("R7 R6 count resumes", err_flag_o, 1);
  endtask

  task automatic t_zero_limit();
    proto_t1_i = 1'b0; tx_mode_i = 1'b0; limit_i = 3'd0; do_clear();
    for (int i = 0; i < 9; i++) rx_char(8'h01, 1'b0);
    chk("R8 rx limit 0", err_flag_o, 0);
    tx_mode_i = 1'b1; do_load();
    for (int i = 0; i < 9; i++) tx_char(1'b1);
    chk("R8 tx limit 0", err_flag_o, 0);
  endtask

  task automatic t_wrong_mode();
    proto_t1_i = 1'b0; tx_mode_i = 1'b1; limit_i = 3'd2; do_clear(); do_load();
    rx_char(8'h03, 1'b0);
    chk("R10 good rx in tx mode no write", fifo_we_o, 0);
    rx_char(8'h01, 1'b0);
    chk("R10 bad rx in tx mode no write", fifo_we_o, 0);
    tx_mode_i = 1'b0;
    rx_char(8'h01, 1'b0);
    chk("R10 rx count untouched", err_flag_o, 0);
    tx_nak_i = 1'b1; @(negedge clk); tx_nak_i = 1'b0;
    tx_end_i = 1'b1; @(negedge clk); tx_end_i = 1'b0;
    tx_mode_i = 1'b1;
    tx_char(1'b1);
    chk("R10 tx count untouched", err_flag_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 50000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_rx_store();
    t_rx_limit();
    t_t1();
    t_tx_retry();
    t_zero_limit();
    t_wrong_mode();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule